// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler

This block picks, every clock, which of a handful of resident warps may send work to the execution units, and it can send up to two instructions at once. Each warp presents the two oldest instructions of its queue, already decoded into an execution-unit class, a destination register and two source registers. A scoreboard holds one busy bit per register of every warp. It blocks any instruction that would read or overwrite a register whose result is still in flight.

Exactly one ready warp is chosen by rotating priority. Its oldest instruction issues. The younger instruction goes in the same cycle only if three conditions hold: it does not touch the older one's destination, its own registers are free, and the free issue ports of the unit classes can take both. The execution units are treated as pipelined with one fixed latency. The block reports each returning result on a retire lane that matches the issue slot, and it frees the scoreboard bit in that same cycle.

Issue outputs are combinational from the current queue heads and port counts. The queue owner advances its head by the number of issue strobes seen at the clock edge.

Top module: `dual_issue_sched`

## Requirements
- R1: No more than two instructions issue in a clock. Both come from the warp named on `iss_warp_o`. `iss1_valid_o` is never high unless `iss0_valid_o` is high, so the younger instruction never overtakes the older one.
- R2: The younger head pairs only when it is independent of the older head. Its two sources and its destination must all differ from the older head's destination. Otherwise only the older one issues.
- R3: `unit_free_i[c]` gives the free issue ports of class c in the current cycle. The older head needs at least one. A pair of the same class needs at least two. A pair of different classes needs at least one port in each class. Otherwise the block falls back to single issue, or issues nothing.
- R4: Class codes are 0 for integer/floating ALU, 1 for multiplier and 2 for load/store. A head carrying code 3 never issues.
- R5: Each warp has its own busy bit per register. A bit is set when an instruction writing that register issues, and cleared when its result returns. A head whose source or destination is busy does not issue.
- R6: A result returns exactly LAT clocks after its issue cycle. It is shown on the retire lane of its issue slot (lane 0 for the older instruction, lane 1 for the younger) with its warp and register. A dependent instruction may issue in the return cycle itself.
- R7: Units are pipelined. One port of a class accepts a new instruction every clock, and instructions issued in consecutive clocks retire in consecutive clocks.
- R8: Among warps whose older head can issue, the one chosen is the first found by searching upward (with wrap) from the warp after the last one that issued. After reset, warp 0 has first priority.
- R9: When no warp can issue, both issue strobes are low. The rotating priority is left unchanged. Only result returns alter the scoreboard.
- R10: After reset the scoreboard is clear, no result is in flight, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| h0_valid_i | input | NUM_WARPS | Older head present, per warp |
| h0_cls_i | input | NUM_WARPS*2 | Older head unit class, per warp |
| h0_dst_i | input | NUM_WARPS*REG_AW | Older head destination register |
| h0_srca_i | input | NUM_WARPS*REG_AW | Older head first source register |
| h0_srcb_i | input | NUM_WARPS*REG_AW | Older head second source register |
| h1_valid_i | input | NUM_WARPS | Younger head present, per warp |
| h1_cls_i | input | NUM_WARPS*2 | Younger head unit class |
| h1_dst_i | input | NUM_WARPS*REG_AW | Younger head destination register |
| h1_srca_i | input | NUM_WARPS*REG_AW | Younger head first source register |
| h1_srcb_i | input | NUM_WARPS*REG_AW | Younger head second source register |
| unit_free_i | input | 3*CNT_W | Free issue ports per unit class this cycle |
| iss0_valid_o | output | 1 | Older head of the chosen warp issues |
| iss1_valid_o | output | 1 | Younger head issues alongside |
| iss_warp_o | output | log2(NUM_WARPS) | Chosen warp |
| iss0_cls_o | output | 2 | Unit class of the older issued instruction |
| iss1_cls_o | output | 2 | Unit class of the younger issued instruction |
| ret0_valid_o | output | 1 | Result of a slot-0 issue returns |
| ret1_valid_o | output | 1 | Result of a slot-1 issue returns |
| ret_warp_o | output | log2(NUM_WARPS) | Warp of the returning results |
| ret0_reg_o | output | REG_AW | Register written on lane 0 |
| ret1_reg_o | output | REG_AW | Register written on lane 1 |

## Verification
A result return and a new issue can fall in the same cycle. Sometimes the issue depends on the register being freed (read-after-write or write-after-write on the returning register), and then the freed bit must be reset at once. Directed chains put a dependent instruction behind its producer so that it becomes ready exactly in the return cycle. Random traffic across all four warps, with port counts that change every clock, makes returns, pairing refusals and priority rotation meet in one cycle. A behavioural model with per-register ready times and queue pointers predicts every strobe, warp, class and retire lane. That prediction is compared each clock.

// File: rtl/dis_pkg.sv
package dis_pkg;
    typedef enum logic [1:0] {
        CLS_ALU  = 2'd0,
        CLS_MUL  = 2'd1,
        CLS_LSU  = 2'd2,
        CLS_NONE = 2'd3
    } unit_cls_e;

    localparam int N_CLS = 3;
endpackage

// File: rtl/dis_hazard.sv
module dis_hazard
    import dis_pkg::*;
#(
    parameter int REG_AW = 4,
    parameter int CNT_W  = 2
) (
    input  logic [(1<<REG_AW)-1:0]      busy_i,
    input  logic                        v0_i,
    input  logic [1:0]                  cls0_i,
    input  logic [REG_AW-1:0]           dst0_i,
    input  logic [REG_AW-1:0]           sa0_i,
    input  logic [REG_AW-1:0]           sb0_i,
    input  logic                        v1_i,
    input  logic [1:0]                  cls1_i,
    input  logic [REG_AW-1:0]           dst1_i,
    input  logic [REG_AW-1:0]           sa1_i,
    input  logic [REG_AW-1:0]           sb1_i,
    input  logic [N_CLS-1:0][CNT_W-1:0] free_i,
    output logic                        rdy0_o,
    output logic                        pair_o
);
    logic [3:0][CNT_W-1:0] free_ext;
    logic [CNT_W-1:0]      f0, f1;
    logic                  hz0, hz1, indep, cap1;

    always_comb begin
        free_ext = {{CNT_W{1'b0}}, free_i};
        f0       = free_ext[cls0_i];
        f1       = free_ext[cls1_i];
        hz0      = busy_i[sa0_i] | busy_i[sb0_i] | busy_i[dst0_i];
        hz1      = busy_i[sa1_i] | busy_i[sb1_i] | busy_i[dst1_i];
        indep    = (sa1_i != dst0_i) && (sb1_i != dst0_i) && (dst1_i != dst0_i);
        if (cls1_i == cls0_i) begin
            cap1 = (f1 >= CNT_W'(2));
        end else begin
            cap1 = (f1 != '0);
        end
        rdy0_o = v0_i && (cls0_i != CLS_NONE) && (f0 != '0) && !hz0;
        pair_o = rdy0_o && v1_i && (cls1_i != CLS_NONE) && indep && !hz1 && cap1;
    end
endmodule

// File: rtl/dis_rr_pick.sv
module dis_rr_pick #(
    parameter int NUM_WARPS = 4,
    parameter int WARP_W    = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] req_i,
    input  logic [WARP_W-1:0]    last_i,
    output logic                 any_o,
    output logic [WARP_W-1:0]    pick_o
);
    always_comb begin
        any_o  = 1'b0;
        pick_o = last_i;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            int idx;
            idx = (int'(last_i) + k) % NUM_WARPS;
            if (!any_o && req_i[idx]) begin
                any_o  = 1'b1;
                pick_o = WARP_W'(idx);
            end
        end
    end
endmodule

// File: rtl/dis_retire_pipe.sv
module dis_retire_pipe #(
    parameter int LAT    = 3,
    parameter int WARP_W = 2,
    parameter int REG_AW = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_v0_i,
    input  logic              in_v1_i,
    input  logic [WARP_W-1:0] in_warp_i,
    input  logic [REG_AW-1:0] in_r0_i,
    input  logic [REG_AW-1:0] in_r1_i,
    output logic              ret_v0_o,
    output logic              ret_v1_o,
    output logic [WARP_W-1:0] ret_warp_o,
    output logic [REG_AW-1:0] ret_r0_o,
    output logic [REG_AW-1:0] ret_r1_o
);
    typedef struct packed {
        logic              v0;
        logic              v1;
        logic [WARP_W-1:0] warp;
        logic [REG_AW-1:0] r0;
        logic [REG_AW-1:0] r1;
    } stage_t;

    stage_t [LAT-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = '{v0: in_v0_i, v1: in_v1_i, warp: in_warp_i,
                      r0: in_r0_i, r1: in_r1_i};
        for (int k = 1; k < LAT; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign ret_v0_o   = pipe_q[LAT-1].v0;
    assign ret_v1_o   = pipe_q[LAT-1].v1;
    assign ret_warp_o = pipe_q[LAT-1].warp;
    assign ret_r0_o   = pipe_q[LAT-1].r0;
    assign ret_r1_o   = pipe_q[LAT-1].r1;
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
    import dis_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int REG_AW    = 4,
    parameter int LAT       = 3,
    parameter int CNT_W     = 2,
    localparam int WARP_W   = $clog2(NUM_WARPS),
    localparam int NUM_REGS = 1 << REG_AW
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic [NUM_WARPS-1:0]                  h0_valid_i,
    input  logic [NUM_WARPS-1:0][1:0]             h0_cls_i,
    input  logic [NUM_WARPS-1:0][REG_AW-1:0]      h0_dst_i,
    input  logic [NUM_WARPS-1:0][REG_AW-1:0]      h0_srca_i,
    input  logic [NUM_WARPS-1:0][REG_AW-1:0]      h0_srcb_i,
    input  logic [NUM_WARPS-1:0]                  h1_valid_i,
    input  logic [NUM_WARPS-1:0][1:0]             h1_cls_i,
    input  logic [NUM_WARPS-1:0][REG_AW-1:0]      h1_dst_i,
    input  logic [NUM_WARPS-1:0][REG_AW-1:0]      h1_srca_i,
    input  logic [NUM_WARPS-1:0][REG_AW-1:0]      h1_srcb_i,
    input  logic [N_CLS-1:0][CNT_W-1:0]           unit_free_i,
    output logic                                  iss0_valid_o,
    output logic                                  iss1_valid_o,
    output logic [WARP_W-1:0]                     iss_warp_o,
    output logic [1:0]                            iss0_cls_o,
    output logic [1:0]                            iss1_cls_o,
    output logic                                  ret0_valid_o,
    output logic                                  ret1_valid_o,
    output logic [WARP_W-1:0]                     ret_warp_o,
    output logic [REG_AW-1:0]                     ret0_reg_o,
    output logic [REG_AW-1:0]                     ret1_reg_o
);
    typedef struct packed {
        logic [NUM_WARPS-1:0][NUM_REGS-1:0] sb;
        logic [WARP_W-1:0]                  last;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_WARPS-1:0][NUM_REGS-1:0] busy_eff;
    logic [NUM_WARPS-1:0]               rdy0, pair;
    logic                               any_rdy;
    logic [WARP_W-1:0]                  pick;
    logic                               iss0, iss1;

    // scoreboard view with this cycle's returns already freed
    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                logic hit;
                hit = (ret_warp_o == WARP_W'(w)) &&
                      ((ret0_valid_o && (ret0_reg_o == REG_AW'(r))) ||
                       (ret1_valid_o && (ret1_reg_o == REG_AW'(r))));
                busy_eff[w][r] = st_q.sb[w][r] && !hit;
            end
        end
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        dis_hazard #(
            .REG_AW (REG_AW),
            .CNT_W  (CNT_W)
        ) u_hz (
            .busy_i (busy_eff[w]),
            .v0_i   (h0_valid_i[w]),
            .cls0_i (h0_cls_i[w]),
            .dst0_i (h0_dst_i[w]),
            .sa0_i  (h0_srca_i[w]),
            .sb0_i  (h0_srcb_i[w]),
            .v1_i   (h1_valid_i[w]),
            .cls1_i (h1_cls_i[w]),
            .dst1_i (h1_dst_i[w]),
            .sa1_i  (h1_srca_i[w]),
            .sb1_i  (h1_srcb_i[w]),
            .free_i (unit_free_i),
            .rdy0_o (rdy0[w]),
            .pair_o (pair[w])
        );
    end

    dis_rr_pick #(
        .NUM_WARPS (NUM_WARPS),
        .WARP_W    (WARP_W)
    ) u_pick (
        .req_i  (rdy0),
        .last_i (st_q.last),
        .any_o  (any_rdy),
        .pick_o (pick)
    );

    assign iss0 = any_rdy;
    assign iss1 = any_rdy && pair[pick];

    always_comb begin
        st_d    = st_q;
        st_d.sb = busy_eff;
        if (iss0) begin
            st_d.sb[pick][h0_dst_i[pick]] = 1'b1;
            st_d.last                     = pick;
        end
        if (iss1) begin
            st_d.sb[pick][h1_dst_i[pick]] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.sb   <= '0;
            st_q.last <= WARP_W'(NUM_WARPS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    dis_retire_pipe #(
        .LAT    (LAT),
        .WARP_W (WARP_W),
        .REG_AW (REG_AW)
    ) u_ret (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .in_v0_i    (iss0),
        .in_v1_i    (iss1),
        .in_warp_i  (pick),
        .in_r0_i    (h0_dst_i[pick]),
        .in_r1_i    (h1_dst_i[pick]),
        .ret_v0_o   (ret0_valid_o),
        .ret_v1_o   (ret1_valid_o),
        .ret_warp_o (ret_warp_o),
        .ret_r0_o   (ret0_reg_o),
        .ret_r1_o   (ret1_reg_o)
    );

    assign iss0_valid_o = iss0;
    assign iss1_valid_o = iss1;
    assign iss_warp_o   = pick;
    assign iss0_cls_o   = h0_cls_i[pick];
    assign iss1_cls_o   = h1_cls_i[pick];
endmodule

// File: rtl/dis_sched_chk.sv
module dis_sched_chk
    import dis_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int REG_AW    = 4,
    parameter int LAT       = 3,
    parameter int CNT_W     = 2,
    localparam int WARP_W   = $clog2(NUM_WARPS)
) (
    input logic                             clk_i,
    input logic                             rst_ni,
    input logic [NUM_WARPS-1:0]             h0_valid_i,
    input logic [NUM_WARPS-1:0][1:0]        h0_cls_i,
    input logic [NUM_WARPS-1:0][REG_AW-1:0] h0_dst_i,
    input logic [NUM_WARPS-1:0][REG_AW-1:0] h0_srca_i,
    input logic [NUM_WARPS-1:0][REG_AW-1:0] h0_srcb_i,
    input logic [NUM_WARPS-1:0]             h1_valid_i,
    input logic [NUM_WARPS-1:0][1:0]        h1_cls_i,
    input logic [NUM_WARPS-1:0][REG_AW-1:0] h1_dst_i,
    input logic [NUM_WARPS-1:0][REG_AW-1:0] h1_srca_i,
    input logic [NUM_WARPS-1:0][REG_AW-1:0] h1_srcb_i,
    input logic [N_CLS-1:0][CNT_W-1:0]      unit_free_i,
    input logic                             iss0_valid_o,
    input logic                             iss1_valid_o,
    input logic [WARP_W-1:0]                iss_warp_o,
    input logic [1:0]                       iss0_cls_o,
    input logic [1:0]                       iss1_cls_o,
    input logic                             ret0_valid_o,
    input logic                             ret1_valid_o,
    input logic [WARP_W-1:0]                ret_warp_o,
    input logic [REG_AW-1:0]                ret0_reg_o,
    input logic [REG_AW-1:0]                ret1_reg_o
);
    logic [LAT-1:0]             sh0_q, sh1_q;
    logic [LAT-1:0][WARP_W-1:0] shw_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sh0_q <= '0;
            sh1_q <= '0;
            shw_q <= '0;
        end else begin
            sh0_q[0] <= iss0_valid_o;
            sh1_q[0] <= iss1_valid_o;
            shw_q[0] <= iss_warp_o;
            for (int k = 1; k < LAT; k++) begin
                sh0_q[k] <= sh0_q[k-1];
                sh1_q[k] <= sh1_q[k-1];
                shw_q[k] <= shw_q[k-1];
            end
        end
    end

    // R1
    pair_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss1_valid_o |-> iss0_valid_o);

    // R2
    pair_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss1_valid_o |-> (h1_srca_i[iss_warp_o] != h0_dst_i[iss_warp_o]) &&
                         (h1_srcb_i[iss_warp_o] != h0_dst_i[iss_warp_o]) &&
                         (h1_dst_i[iss_warp_o]  != h0_dst_i[iss_warp_o]));

    // R3
    pair_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss1_valid_o && (iss0_cls_o == iss1_cls_o) && (iss0_cls_o != CLS_NONE))
            |-> (unit_free_i[iss0_cls_o] >= CNT_W'(2)));

    // R4
    no_none_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss0_valid_o |-> (iss0_cls_o != CLS_NONE) && h0_valid_i[iss_warp_o]);

    // R6
    ret0_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret0_valid_o == sh0_q[LAT-1]);

    // R6
    ret1_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret1_valid_o == sh1_q[LAT-1]);

    // R6
    ret_warp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret0_valid_o |-> (ret_warp_o == shw_q[LAT-1]));
endmodule

bind dual_issue_sched dis_sched_chk #(
    .NUM_WARPS (NUM_WARPS),
    .REG_AW    (REG_AW),
    .LAT       (LAT),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/dual_issue_sched_tb.sv
module dual_issue_sched_tb;
    localparam int NW  = 4;
    localparam int AW  = 4;
    localparam int LAT = 3;
    localparam int CW  = 2;
    localparam int WW  = 2;
    localparam int NR  = 16;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    always #5 clk = ~clk;

    logic [NW-1:0]          h0_valid, h1_valid;
    logic [NW-1:0][1:0]     h0_cls, h1_cls;
    logic [NW-1:0][AW-1:0]  h0_dst, h0_sa, h0_sb, h1_dst, h1_sa, h1_sb;
    logic [2:0][CW-1:0]     ufree;
    logic                   iss0_valid, iss1_valid, ret0_valid, ret1_valid;
    logic [WW-1:0]          iss_warp, ret_warp;
    logic [1:0]             iss0_cls, iss1_cls;
    logic [AW-1:0]          ret0_reg, ret1_reg;

    dual_issue_sched #(.NUM_WARPS(NW), .REG_AW(AW), .LAT(LAT), .CNT_W(CW)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni),
        .h0_valid_i(h0_valid), .h0_cls_i(h0_cls), .h0_dst_i(h0_dst),
        .h0_srca_i(h0_sa), .h0_srcb_i(h0_sb),
        .h1_valid_i(h1_valid), .h1_cls_i(h1_cls), .h1_dst_i(h1_dst),
        .h1_srca_i(h1_sa), .h1_srcb_i(h1_sb),
        .unit_free_i(ufree),
        .iss0_valid_o(iss0_valid), .iss1_valid_o(iss1_valid), .iss_warp_o(iss_warp),
        .iss0_cls_o(iss0_cls), .iss1_cls_o(iss1_cls),
        .ret0_valid_o(ret0_valid), .ret1_valid_o(ret1_valid), .ret_warp_o(ret_warp),
        .ret0_reg_o(ret0_reg), .ret1_reg_o(ret1_reg)
    );

    int total = 0;
    int bad = 0;
    logic [13:0] prog [NW][64];
    int plen [NW];
    int ptr [NW];
    int ready_at [NW][NR];
    int last = NW - 1;
    int cyc = 0;
    int fr [3];
    bit rand_fr = 0;
    bit e_v0 [8], e_v1 [8];
    int e_w [8], e_r0 [8], e_r1 [8];
    string tag = "R10";

    function automatic logic [13:0] mk(int c, int d, int a, int b);
        return {2'(c), 4'(d), 4'(a), 4'(b)};
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d cyc=%0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic put(int w, logic [13:0] ins);
        prog[w][plen[w]] = ins;
        plen[w]++;
    endtask

    task automatic clear_progs();
        for (int w = 0; w < NW; w++) begin
            plen[w] = 0;
            ptr[w] = 0;
        end
    endtask

    task automatic drive();
        if (rand_fr) begin
            for (int c = 0; c < 3; c++) fr[c] = $urandom_range(0, 3);
        end
        for (int c = 0; c < 3; c++) ufree[c] = CW'(fr[c]);
        for (int w = 0; w < NW; w++) begin
            logic [13:0] i0, i1;
            i0 = (ptr[w] < plen[w]) ? prog[w][ptr[w]] : '0;
            i1 = (ptr[w] + 1 < plen[w]) ? prog[w][ptr[w] + 1] : '0;
            h0_valid[w] = (ptr[w] < plen[w]);
            h1_valid[w] = (ptr[w] + 1 < plen[w]);
            h0_cls[w] = i0[13:12]; h0_dst[w] = i0[11:8]; h0_sa[w] = i0[7:4]; h0_sb[w] = i0[3:0];
            h1_cls[w] = i1[13:12]; h1_dst[w] = i1[11:8]; h1_sa[w] = i1[7:4]; h1_sb[w] = i1[3:0];
        end
    endtask

    function automatic bit busy(int w, int r);
        return cyc < ready_at[w][r];
    endfunction

    function automatic bit can0(int w);
        logic [13:0] i;
        int c;
        if (ptr[w] >= plen[w]) return 0;
        i = prog[w][ptr[w]];
        c = int'(i[13:12]);
        if (c == 3) return 0;
        if (fr[c] < 1) return 0;
        return !busy(w, int'(i[11:8])) && !busy(w, int'(i[7:4])) && !busy(w, int'(i[3:0]));
    endfunction

    function automatic bit can1(int w);
        logic [13:0] i0, i1;
        int c0, c1, d0;
        if (ptr[w] + 1 >= plen[w]) return 0;
        i0 = prog[w][ptr[w]];
        i1 = prog[w][ptr[w] + 1];
        c0 = int'(i0[13:12]);
        c1 = int'(i1[13:12]);
        d0 = int'(i0[11:8]);
        if (c1 == 3) return 0;
        if (int'(i1[11:8]) == d0 || int'(i1[7:4]) == d0 || int'(i1[3:0]) == d0) return 0;
        if (busy(w, int'(i1[11:8])) || busy(w, int'(i1[7:4])) || busy(w, int'(i1[3:0]))) return 0;
        if (c1 == c0) return fr[c1] >= 2;
        return fr[c1] >= 1;
    endfunction

    task automatic model_compare();
        int pw, s, now;
        bit e0, e1;
        pw = -1;
        for (int k = 1; k <= NW; k++) begin
            int w;
            w = (last + k) % NW;
            if (pw < 0 && can0(w)) pw = w;
        end
        e0 = (pw >= 0);
        e1 = e0 && can1(pw);
        check(tag, "iss0_valid", int'(iss0_valid), int'(e0));
        check(tag, "iss1_valid", int'(iss1_valid), int'(e1));
        if (e0) begin
            check(tag, "iss_warp", int'(iss_warp), pw);
            check(tag, "iss0_cls", int'(iss0_cls), int'(prog[pw][ptr[pw]][13:12]));
        end
        if (e1) check(tag, "iss1_cls", int'(iss1_cls), int'(prog[pw][ptr[pw] + 1][13:12]));
        now = cyc % 8;
        check(tag, "ret0_valid", int'(ret0_valid), int'(e_v0[now]));
        check(tag, "ret1_valid", int'(ret1_valid), int'(e_v1[now]));
        if (e_v0[now] || e_v1[now]) check(tag, "ret_warp", int'(ret_warp), e_w[now]);
        if (e_v0[now]) check(tag, "ret0_reg", int'(ret0_reg), e_r0[now]);
        if (e_v1[now]) check(tag, "ret1_reg", int'(ret1_reg), e_r1[now]);
        e_v0[now] = 0;
        e_v1[now] = 0;
        s = (cyc + LAT) % 8;
        if (e0) begin
            e_v0[s] = 1;
            e_w[s] = pw;
            e_r0[s] = int'(prog[pw][ptr[pw]][11:8]);
            ready_at[pw][e_r0[s]] = cyc + LAT;
            last = pw;
        end
        if (e1) begin
            e_v1[s] = 1;
            e_r1[s] = int'(prog[pw][ptr[pw] + 1][11:8]);
            ready_at[pw][e_r1[s]] = cyc + LAT;
        end
        if (e0) ptr[pw] += e1 ? 2 : 1;
        cyc++;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        drive();
        @(negedge clk);
        model_compare();
    endtask

    task automatic run_steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            bit done;
            done = 1;
            for (int w = 0; w < NW; w++) if (ptr[w] < plen[w]) done = 0;
            if (done) break;
            step();
        end
        run_steps(LAT + 1);
        clear_progs();
    endtask

    task automatic set_fr(int a, int m, int l);
        fr[0] = a; fr[1] = m; fr[2] = l;
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin
            for (int r = 0; r < NR; r++) ready_at[w][r] = 0;
        end
        for (int i = 0; i < 8; i++) begin
            e_v0[i] = 0; e_v1[i] = 0; e_w[i] = 0; e_r0[i] = 0; e_r1[i] = 0;
        end
        clear_progs();
        set_fr(3, 3, 3);
        drive();
        repeat (3) @(posedge clk);
        #1 rst_ni = 1'b1;

        // R10: quiet after reset
        tag = "R10";
        run_steps(3);

        // R2: RAW, WAW and independent pairs in one warp
        tag = "R2";
        put(0, mk(0, 1, 2, 3)); put(0, mk(0, 4, 1, 5));
        put(0, mk(0, 6, 7, 8)); put(0, mk(1, 6, 9, 9));
        put(0, mk(0, 10, 11, 12)); put(0, mk(2, 13, 14, 15));
        put(0, mk(1, 2, 3, 0)); put(0, mk(0, 0, 3, 3));
        drain();

        // R3: port counts limit pairing
        tag = "R3";
        set_fr(0, 0, 0);
        put(0, mk(0, 1, 0, 0)); put(0, mk(0, 2, 0, 0));
        put(0, mk(0, 3, 0, 0)); put(0, mk(1, 4, 0, 0));
        run_steps(3);
        set_fr(1, 1, 1);
        drain();
        set_fr(2, 1, 0);
        put(1, mk(0, 5, 0, 0)); put(1, mk(0, 6, 0, 0));
        put(1, mk(1, 7, 0, 0)); put(1, mk(2, 8, 0, 0));
        put(1, mk(1, 9, 0, 0));
        run_steps(6);
        set_fr(3, 3, 3);
        drain();

        // R4: class code 3 never issues
        tag = "R4";
        put(1, mk(3, 1, 0, 0));
        put(2, mk(0, 2, 0, 0)); put(2, mk(3, 3, 0, 0));
        run_steps(6);
        clear_progs();
        run_steps(LAT + 1);

        // R5: per-warp scoreboard, chains in two warps on same registers
        tag = "R5";
        put(0, mk(0, 1, 0, 0)); put(0, mk(1, 2, 1, 0)); put(0, mk(2, 3, 2, 1));
        put(3, mk(0, 1, 0, 0)); put(3, mk(0, 1, 4, 4)); put(3, mk(2, 5, 1, 1));
        drain();

        // R6: dependent issues in the return cycle
        tag = "R6";
        put(2, mk(1, 5, 0, 0)); put(2, mk(0, 6, 5, 0)); put(2, mk(0, 5, 6, 6));
        drain();

        // R7: one multiplier port, back-to-back issue and return
        tag = "R7";
        set_fr(3, 1, 3);
        for (int i = 1; i <= 6; i++) put(0, mk(1, i, 0, 0));
        drain();

        // R8: rotating priority across four warps
        tag = "R8";
        set_fr(1, 0, 0);
        for (int w = 0; w < NW; w++) begin
            for (int i = 0; i < 3; i++) put(w, mk(0, i + 1, 0, 0));
        end
        drain();
        put(1, mk(0, 7, 0, 0));
        put(3, mk(0, 8, 0, 0));
        drain();

        // R9: nothing ready leaves priority untouched
        tag = "R9";
        set_fr(3, 3, 3);
        run_steps(4);
        put(0, mk(0, 9, 0, 0));
        put(2, mk(0, 9, 0, 0));
        drain();

        // R1: random mix with changing port counts
        tag = "R1";
        rand_fr = 1;
        for (int w = 0; w < NW; w++) begin
            for (int i = 0; i < 60; i++) begin
                put(w, mk($urandom_range(0, 2), $urandom_range(0, 15),
                          $urandom_range(0, 15), $urandom_range(0, 15)));
            end
        end
        drain();
        rand_fr = 0;

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        summary();
        $finish;
    end
endmodule